// File: doc/BRIEF.md
# Configurable multiply-accumulate unit

This block multiplies two 16-bit operands and keeps a 35-bit running result in an output register. The result is split into a 3-bit guard field (bits 34..32), a 16-bit upper field (bits 31..16) and a 16-bit lower field (bits 15..0). The operands may be treated as signed two's-complement or as unsigned magnitudes. Each product can replace the result, be added to it or be subtracted from it. An optional rounding step adds one at bit 15.

Everything runs on a single clock with three load enables. `x_load` captures the X operand and `y_load` captures the Y operand. Whenever either of these fires, the four mode inputs (signed, accumulate, subtract, round) are captured into a control register. `p_load` updates the result register from the captured operands and the captured modes. The live mode inputs play no part in that update.

Each result field has an active-low output enable. In preload mode all enables go inactive, and the same per-field controls instead pick which fields take external data on `p_load`. The data outputs always show the register contents; the separate `*_en` outputs tell a pad ring or a bus when to drive them. The control pins are plain levels sampled at the clock edge. There is no handshake and no back-pressure: a load enable is acted on in the cycle it is high.

Top module: `mac_unit`

## Requirements
- R1: The X operand register loads `x_in` only on a clock edge with `x_load`=1, and the Y register loads `y_in` only with `y_load`=1. The mode control register (signed, accumulate, subtract, round) loads from `tc_in`, `acc_in`, `sub_in` and `rnd_in` on any edge where `x_load` or `y_load` is 1.
- R2: When `p_load`=1, `prel`=0 and the captured accumulate bit is 0, the result becomes the product alone and the subtract bit has no effect. With the signed bit at 1, both operands are signed and the product is sign-extended into bits 34..32. With the signed bit at 0, both operands are unsigned and bits 34..32 are zero.
- R3: With captured accumulate=1 and subtract=0, `p_load` writes (result + product) mod 2^35.
- R4: With captured accumulate=1 and subtract=1, `p_load` writes (result − product) mod 2^35.
- R5: With the captured round bit at 1, 2^15 is added to the value written by R2–R4 before it is stored.
- R6: The `p_load` update uses the mode bits held in the control register. A mode input that changes without an operand load does not affect the result.
- R7: On an edge with `p_load`=0 and `rst`=0, the result register keeps its value whatever the other inputs do.
- R8: With `prel`=0, each field enable output (`xt_en`, `ms_en`, `ls_en`) is the inverse of its active-low control (`oe_xt_n`, `oe_ms_n`, `oe_ls_n`). With `prel`=1, all three enable outputs are 0.
- R9: With `prel`=1, `p_load` loads each field whose control is 1 from `pre_xt`, `pre_ms` or `pre_ls`. Each field whose control is 0 keeps its value.
- R10: A synchronous active-high `rst` clears both operand registers, the control register and the result register. After reset all data outputs read 0.
- R11: In signed mode, 0x8000 × 0x8000 yields +2^30 (0x0_4000_0000), with no overflow into the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_load | input | 1 | Capture X operand and modes |
| y_load | input | 1 | Capture Y operand and modes |
| p_load | input | 1 | Update result register |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| tc_in | input | 1 | 1 = signed operands, 0 = unsigned |
| acc_in | input | 1 | 1 = accumulate into result |
| sub_in | input | 1 | 1 = subtract product when accumulating |
| rnd_in | input | 1 | 1 = add 2^15 before storing |
| prel | input | 1 | Preload mode |
| oe_xt_n | input | 1 | Guard-field enable (active low) / preload select |
| oe_ms_n | input | 1 | Upper-field enable (active low) / preload select |
| oe_ls_n | input | 1 | Lower-field enable (active low) / preload select |
| pre_xt | input | 3 | Preload data, guard field |
| pre_ms | input | 16 | Preload data, upper field |
| pre_ls | input | 16 | Preload data, lower field |
| xt_out | output | 3 | Result bits 34..32 |
| ms_out | output | 16 | Result bits 31..16 |
| ls_out | output | 16 | Result bits 15..0 |
| xt_en | output | 1 | Guard field drive enable |
| ms_en | output | 1 | Upper field drive enable |
| ls_en | output | 1 | Lower field drive enable |

## Verification
The hardest case to reach from the ports is one where the captured modes differ from the live ones when `p_load` fires. In that case a result built from live inputs and a result built from captured inputs disagree. The directed part therefore loads the operands with one set of modes, changes every mode input without an operand load, and then pulses `p_load`. The random part draws the three load enables independently, so operand loads, mode changes, preloads and result updates often fall in the same cycle. Extreme operands and accumulation wrap-around come from the directed cases: the most negative value squared, all-ones unsigned, and a negative product with guard-bit sign extension.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic tc;
    logic acc;
    logic sub;
    logic rnd;
  } mode_t;
endpackage

// File: rtl/mac_in_regs.sv
module mac_in_regs
  import mac_pkg::*;
#(
  parameter int XW = 16,
  parameter int YW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_load,
  input  logic          y_load,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  input  mode_t         mode_in,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q,
  output mode_t         mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= '0;
    end else begin
      if (x_load) x_q <= x_in;
      if (y_load) y_q <= y_in;
      if (x_load || y_load) mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/mac_core.sv
module mac_core
  import mac_pkg::*;
#(
  parameter int XW  = 16,
  parameter int YW  = 16,
  parameter int GW  = 3,
  parameter int LSW = 16
) (
  input  logic [XW-1:0]       x_q,
  input  logic [YW-1:0]       y_q,
  input  mode_t               mode_q,
  input  logic [XW+YW+GW-1:0] acc_q,
  output logic [XW+YW+GW-1:0] next_val
);
  localparam int RW = XW + YW + GW;
  localparam logic [RW-1:0] ONE   = {{(RW-1){1'b0}}, 1'b1};
  localparam logic [RW-1:0] RND_K = ONE << (LSW - 1);

  logic [RW-1:0] x_ext, y_ext, prod, base, term, rnd_term;

  always_comb begin
    x_ext    = {{(RW-XW){mode_q.tc & x_q[XW-1]}}, x_q};
    y_ext    = {{(RW-YW){mode_q.tc & y_q[YW-1]}}, y_q};
    prod     = x_ext * y_ext;
    base     = mode_q.acc ? acc_q : '0;
    term     = (mode_q.acc && mode_q.sub) ? (~prod + ONE) : prod;
    rnd_term = mode_q.rnd ? RND_K : '0;
    next_val = base + term + rnd_term;
  end
endmodule

// File: rtl/mac_field_reg.sv
module mac_field_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         p_load,
  input  logic         prel,
  input  logic         sel_n,
  input  logic [W-1:0] d_calc,
  input  logic [W-1:0] d_pre,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (p_load) begin
      if (!prel)      q <= d_calc;
      else if (sel_n) q <= d_pre;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XW  = 16,
  parameter int YW  = 16,
  parameter int GW  = 3,
  parameter int LSW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 x_load,
  input  logic                 y_load,
  input  logic                 p_load,
  input  logic [XW-1:0]        x_in,
  input  logic [YW-1:0]        y_in,
  input  logic                 tc_in,
  input  logic                 acc_in,
  input  logic                 sub_in,
  input  logic                 rnd_in,
  input  logic                 prel,
  input  logic                 oe_xt_n,
  input  logic                 oe_ms_n,
  input  logic                 oe_ls_n,
  input  logic [GW-1:0]        pre_xt,
  input  logic [XW+YW-LSW-1:0] pre_ms,
  input  logic [LSW-1:0]       pre_ls,
  output logic [GW-1:0]        xt_out,
  output logic [XW+YW-LSW-1:0] ms_out,
  output logic [LSW-1:0]       ls_out,
  output logic                 xt_en,
  output logic                 ms_en,
  output logic                 ls_en
);
  localparam int PW  = XW + YW;
  localparam int RW  = PW + GW;
  localparam int MSW = PW - LSW;

  mode_t          mode_in, mode_q;
  logic [XW-1:0]  x_q;
  logic [YW-1:0]  y_q;
  logic [RW-1:0]  acc_q, next_val;

  assign mode_in = '{tc: tc_in, acc: acc_in, sub: sub_in, rnd: rnd_in};

  mac_in_regs #(.XW(XW), .YW(YW)) u_in (
    .clk(clk), .rst(rst), .x_load(x_load), .y_load(y_load),
    .x_in(x_in), .y_in(y_in), .mode_in(mode_in),
    .x_q(x_q), .y_q(y_q), .mode_q(mode_q)
  );

  mac_core #(.XW(XW), .YW(YW), .GW(GW), .LSW(LSW)) u_core (
    .x_q(x_q), .y_q(y_q), .mode_q(mode_q), .acc_q(acc_q), .next_val(next_val)
  );

  mac_field_reg #(.W(GW)) u_xt (
    .clk(clk), .rst(rst), .p_load(p_load), .prel(prel), .sel_n(oe_xt_n),
    .d_calc(next_val[RW-1:PW]), .d_pre(pre_xt), .q(xt_out)
  );

  mac_field_reg #(.W(MSW)) u_ms (
    .clk(clk), .rst(rst), .p_load(p_load), .prel(prel), .sel_n(oe_ms_n),
    .d_calc(next_val[PW-1:LSW]), .d_pre(pre_ms), .q(ms_out)
  );

  mac_field_reg #(.W(LSW)) u_ls (
    .clk(clk), .rst(rst), .p_load(p_load), .prel(prel), .sel_n(oe_ls_n),
    .d_calc(next_val[LSW-1:0]), .d_pre(pre_ls), .q(ls_out)
  );

  assign acc_q = {xt_out, ms_out, ls_out};
  assign xt_en = !prel && !oe_xt_n;
  assign ms_en = !prel && !oe_ms_n;
  assign ls_en = !prel && !oe_ls_n;
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int XW  = 16,
  parameter int YW  = 16,
  parameter int GW  = 3,
  parameter int LSW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 x_load,
  input logic                 y_load,
  input logic                 p_load,
  input logic                 prel,
  input logic                 oe_ms_n,
  input logic [XW+YW-LSW-1:0] pre_ms,
  input logic [XW-1:0]        x_q,
  input logic [YW-1:0]        y_q,
  input logic [GW-1:0]        xt_out,
  input logic [XW+YW-LSW-1:0] ms_out,
  input logic [LSW-1:0]       ls_out,
  input logic                 xt_en,
  input logic                 ms_en,
  input logic                 ls_en
);
  assert_xhold_R1: assert property (@(posedge clk) disable iff (rst)
    !x_load |=> $stable(x_q));
  assert_yhold_R1: assert property (@(posedge clk) disable iff (rst)
    !y_load |=> $stable(y_q));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !p_load |=> $stable({xt_out, ms_out, ls_out}));
  assert_prel_off_R8: assert property (@(posedge clk) disable iff (rst)
    prel |-> !(xt_en || ms_en || ls_en));
  assert_pre_load_R9: assert property (@(posedge clk) disable iff (rst)
    (p_load && prel && oe_ms_n) |=> (ms_out == $past(pre_ms)));
  assert_pre_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (p_load && prel && !oe_ms_n) |=> $stable(ms_out));
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> ({xt_out, ms_out, ls_out} == '0));
endmodule

bind mac_unit mac_checker #(.XW(XW), .YW(YW), .GW(GW), .LSW(LSW)) u_chk (
  .clk(clk), .rst(rst), .x_load(x_load), .y_load(y_load), .p_load(p_load),
  .prel(prel), .oe_ms_n(oe_ms_n), .pre_ms(pre_ms), .x_q(x_q), .y_q(y_q),
  .xt_out(xt_out), .ms_out(ms_out), .ls_out(ls_out),
  .xt_en(xt_en), .ms_en(ms_en), .ls_en(ls_en)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, x_load, y_load, p_load, tc_in, acc_in, sub_in, rnd_in, prel;
  logic oe_xt_n, oe_ms_n, oe_ls_n;
  logic [15:0] x_in, y_in, pre_ms, pre_ls;
  logic [2:0]  pre_xt, xt_out;
  logic [15:0] ms_out, ls_out;
  logic xt_en, ms_en, ls_en;

  mac_unit u0 (
    .clk(clk), .rst(rst), .x_load(x_load), .y_load(y_load), .p_load(p_load),
    .x_in(x_in), .y_in(y_in), .tc_in(tc_in), .acc_in(acc_in), .sub_in(sub_in),
    .rnd_in(rnd_in), .prel(prel), .oe_xt_n(oe_xt_n), .oe_ms_n(oe_ms_n),
    .oe_ls_n(oe_ls_n), .pre_xt(pre_xt), .pre_ms(pre_ms), .pre_ls(pre_ls),
    .xt_out(xt_out), .ms_out(ms_out), .ls_out(ls_out),
    .xt_en(xt_en), .ms_en(ms_en), .ls_en(ls_en)
  );

  int total = 0, bad = 0;
  logic [15:0] mx, my;
  logic mtc, macc, msub, mrnd;
  logic [34:0] mp;

  function automatic logic [34:0] ref_next(logic [34:0] p, logic [15:0] x, logic [15:0] y,
                                           logic tc, logic acc, logic sub, logic rnd);
    longint sx, sy, pr, r;
    sx = tc ? longint'($signed(x)) : longint'(x);
    sy = tc ? longint'($signed(y)) : longint'(y);
    pr = sx * sy;
    if (acc) r = sub ? (longint'(p) - pr) : (longint'(p) + pr);
    else     r = pr;
    if (rnd) r = r + 64'sd32768;
    return r[34:0];
  endfunction

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    x_load = 0; y_load = 0; p_load = 0; prel = 0;
  endtask

  // Apply current inputs over one edge, update the model, compare at the falling edge.
  task automatic step(string tag);
    logic [34:0] nxt;
    @(posedge clk);
    nxt = mp;
    if (rst) begin
      mx = 0; my = 0; {mtc, macc, msub, mrnd} = 4'b0; mp = 0;
    end else begin
      if (p_load) begin
        if (!prel) nxt = ref_next(mp, mx, my, mtc, macc, msub, mrnd);
        else begin
          if (oe_xt_n) nxt[34:32] = pre_xt;
          if (oe_ms_n) nxt[31:16] = pre_ms;
          if (oe_ls_n) nxt[15:0]  = pre_ls;
        end
      end
      if (x_load) mx = x_in;
      if (y_load) my = y_in;
      if (x_load || y_load) {mtc, macc, msub, mrnd} = {tc_in, acc_in, sub_in, rnd_in};
      mp = nxt;
    end
    @(negedge clk);
    chk(tag, {xt_out, ms_out, ls_out}, mp);
    chk({tag, " R8 enables"}, {29'b0, xt_en, ms_en, ls_en},
        {29'b0, !prel && !oe_xt_n, !prel && !oe_ms_n, !prel && !oe_ls_n});
  endtask

  task automatic op(string tag, logic [15:0] x, logic [15:0] y,
                    logic tc, logic acc, logic sub, logic rnd);
    idle();
    x_in = x; y_in = y; x_load = 1; y_load = 1;
    {tc_in, acc_in, sub_in, rnd_in} = {tc, acc, sub, rnd};
    step({tag, " R1 load"});
    idle(); p_load = 1;
    step(tag);
    idle();
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mp = 0; mx = 0; my = 0; {mtc, macc, msub, mrnd} = 4'b0;
    @(negedge clk);
    rst = 1; idle(); x_in = 0; y_in = 0; {tc_in, acc_in, sub_in, rnd_in} = 4'b0;
    oe_xt_n = 0; oe_ms_n = 0; oe_ls_n = 0; pre_xt = 0; pre_ms = 0; pre_ls = 0;
    step("R10 reset");
    step("R10 reset");
    chk("R10 outputs zero", {xt_out, ms_out, ls_out}, 35'h0);
    rst = 0;

    op("R11 min squared", 16'h8000, 16'h8000, 1, 0, 0, 0);
    chk("R11 value", {xt_out, ms_out, ls_out}, 35'h0_4000_0000);
    op("R2 unsigned", 16'hFFFF, 16'hFFFF, 0, 0, 1, 0);
    chk("R2 unsigned value", {xt_out, ms_out, ls_out}, 35'h0_FFFE_0001);
    op("R2 signed neg", 16'hFFFD, 16'h0005, 1, 0, 1, 0);
    chk("R2 sign extend", {xt_out, ms_out, ls_out}, 35'h7_FFFF_FFF1);
    op("R3 add", 16'h0002, 16'h0003, 1, 1, 0, 0);
    chk("R3 value", {xt_out, ms_out, ls_out}, 35'h7_FFFF_FFF7);
    op("R4 sub", 16'h0004, 16'h0001, 1, 1, 1, 0);
    chk("R4 value", {xt_out, ms_out, ls_out}, 35'h7_FFFF_FFF3);
    op("R5 round", 16'h0000, 16'h0000, 0, 0, 0, 1);
    chk("R5 value", {xt_out, ms_out, ls_out}, 35'h0_0000_8000);

    op("R6 setup", 16'h0001, 16'h0001, 0, 1, 0, 0);
    chk("R6 setup value", {xt_out, ms_out, ls_out}, 35'h0_0000_8001);
    idle(); {tc_in, acc_in, sub_in, rnd_in} = 4'b1011; p_load = 1;
    step("R6 live modes ignored");
    chk("R6 value", {xt_out, ms_out, ls_out}, 35'h0_0000_8002);

    idle(); x_in = 16'h1234; y_in = 16'h5678; x_load = 1; pre_ms = 16'hBEEF;
    step("R7 hold");
    chk("R7 value", {xt_out, ms_out, ls_out}, 35'h0_0000_8002);

    idle(); prel = 1; oe_xt_n = 1; oe_ms_n = 0; oe_ls_n = 1;
    pre_xt = 3'h5; pre_ms = 16'hAAAA; pre_ls = 16'hC3C3; p_load = 1;
    step("R9 preload");
    chk("R9 value", {xt_out, ms_out, ls_out}, {3'h5, 16'h0000, 16'hC3C3});
    chk("R8 all off in preload", {32'b0, xt_en, ms_en, ls_en}, 35'h0);
    idle(); oe_xt_n = 0; oe_ms_n = 1; oe_ls_n = 0;
    step("R8 enables mixed");
    chk("R8 ms off", {32'b0, xt_en, ms_en, ls_en}, 35'h5);

    for (int i = 0; i < 3000; i++) begin
      x_load = ($urandom % 3) == 0; y_load = ($urandom % 3) == 0;
      p_load = ($urandom % 2) == 0; prel = ($urandom % 6) == 0;
      x_in = 16'($urandom); y_in = 16'($urandom);
      if ($urandom % 8 == 0) x_in = 16'h8000;
      {tc_in, acc_in, sub_in, rnd_in} = 4'($urandom);
      {oe_xt_n, oe_ms_n, oe_ls_n} = 3'($urandom);
      pre_xt = 3'($urandom); pre_ms = 16'($urandom); pre_ls = 16'($urandom);
      step("R1 R2 R3 R4 R5 R9 random");
    end

    idle(); rst = 1;
    step("R10 late reset");
    rst = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule